// File: doc/BRIEF.md
# Fail-Safe Clock Monitor and Switch

This block decides which of two clocks should drive the system. One is a primary oscillator that may be slow to start or may stop. The other is an internal reference clock that always runs. All of the block's decisions are made in the reference clock domain. The block drives a clock-select line into an external glitch-free clock multiplexer.

After reset the select points at the internal clock. It stays there until an external start-up timer reports that the primary oscillator has settled. A primary oscillator that is slow to start, or never starts, is therefore not treated as a fault. Once the primary clock is selected, the monitor divides the reference clock by a parameterised ratio, 64 by default, to make a sample period. In every sample period it requires the primary clock to show falling edges. This works like a flag that primary falling edges set and that each sample edge clears. Internally it is built as a request/acknowledge toggle pair: the request is toggled in the reference domain, echoed back on primary falling edges, and brought home through a two-stage synchroniser.

If a sample edge finds the echo missing, the block declares a failure. It moves the select back to the internal clock, raises a sticky failure flag and stays on the internal clock until the next reset. Software can clear the flag. An enable input turns the detection on and off.

Top module: `fscm_top`

## Requirements
- R1: While `rst` is high, at each rising `int_clk` edge, `sel_primary`, `pri_active` and `fail_flag` are all driven to 0.
- R2: After reset the select stays on the internal clock (`sel_primary`=0) for as long as `ost_done` is 0. It switches to the primary clock (`sel_primary`=1) at the first rising `int_clk` edge that samples `ost_done`=1.
- R3: While the block waits for `ost_done`, a primary clock that is stopped never raises `fail_flag`.
- R4: With the primary clock selected and `mon_en`=1, a running primary clock never raises `fail_flag`. This holds whether its frequency is above, equal to or below the reference frequency, as long as its period is under about one sixth of a sample period.
- R5: With the primary clock selected and `mon_en`=1, a stopped primary clock raises `fail_flag` within 2*SAMPLE_DIV+8 reference cycles. `sel_primary` drops to 0 at the same edge.
- R6: `pri_active` reads 1 exactly when the primary clock is selected and 0 when the internal clock is selected.
- R7: `fail_flag` stays at 1 until `fail_clr` is sampled high; a set in the same cycle takes priority over the clear. After a failure the select stays on the internal clock until reset, even if the primary clock restarts or the flag is cleared.
- R8: While `mon_en`=0, a stopped primary clock raises no failure and the primary clock stays selected. Re-enabling with a running primary clock raises no failure.
- R9: A reset after a failure restores the start-up state. The select then returns to the primary clock through the normal `ost_done` path.
- R10: A primary clock whose period is longer than a sample period is reported as failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pri_clk | input | 1 | Primary oscillator clock under watch |
| int_clk | input | 1 | Always-running internal reference clock |
| rst | input | 1 | Synchronous active-high reset (int_clk domain) |
| mon_en | input | 1 | Enables failure detection |
| ost_done | input | 1 | Start-up timer of the primary oscillator has expired |
| fail_clr | input | 1 | Clears the sticky failure flag |
| sel_primary | output | 1 | Clock select: 1 = primary, 0 = internal |
| pri_active | output | 1 | Status: primary clock is driving the system |
| fail_flag | output | 1 | Sticky primary clock failure indication |

## Verification
The bench runs the primary clock at half-periods from 1.5 ns to 8.5 ns against a 10 ns reference. These runs separate a correct handshake from one that aliases when the two clocks share a ratio or phase. Stopping the primary clock in the start-up state, with detection disabled, and with detection enabled shows that only the last case is reported. The recorded detection latency is compared with the two-period bound. A 200 ns primary period covers the too-slow boundary. Restart, flag clear and reset after a failure show that the select and the flag hold or release independently.

// File: rtl/fscm_pkg.sv
`timescale 1ns/1ps
package fscm_pkg;

    typedef enum logic [1:0] {
        MODE_BOOT    = 2'd0,
        MODE_PRIMARY = 2'd1,
        MODE_SAFE    = 2'd2
    } clk_mode_e;

    typedef struct packed {
        logic tick;
        logic miss;
    } mon_evt_t;

    function automatic logic drives_primary(clk_mode_e m);
        return m == MODE_PRIMARY;
    endfunction

endpackage

// File: rtl/fscm_sample_div.sv
`timescale 1ns/1ps
module fscm_sample_div #(
    parameter int DIV = 64
) (
    input  logic int_clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge int_clk) begin
        if (rst || cnt == LAST) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/fscm_edge_mon.sv
`timescale 1ns/1ps
module fscm_edge_mon
    import fscm_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic     int_clk,
    input  logic     pri_clk,
    input  logic     rst,
    input  logic     arm,
    input  logic     tick,
    output mon_evt_t evt
);
    logic            req;
    logic            armed;
    logic            miss_q;
    logic [SYNC-1:0] ack_sync;
    logic [SYNC-1:0] req_sync;
    logic            ack;

    // primary domain: echo the request on every falling edge
    always_ff @(negedge pri_clk) begin
        if (rst) begin
            req_sync <= '0;
            ack      <= 1'b0;
        end else begin
            req_sync <= {req_sync[SYNC-2:0], req};
            ack      <= req_sync[SYNC-1];
        end
    end

    always_ff @(posedge int_clk) begin
        if (rst) ack_sync <= '0;
        else     ack_sync <= {ack_sync[SYNC-2:0], ack};
    end

    always_ff @(posedge int_clk) begin
        if (rst) begin
            req    <= 1'b0;
            armed  <= 1'b0;
            miss_q <= 1'b0;
        end else if (!arm) begin
            armed  <= 1'b0;
            miss_q <= 1'b0;
        end else begin
            miss_q <= 1'b0;
            if (tick) begin
                if (armed && ack_sync[SYNC-1] != req) miss_q <= 1'b1;
                req   <= ~req;
                armed <= 1'b1;
            end
        end
    end

    assign evt.tick = tick;
    assign evt.miss = miss_q;
endmodule

// File: rtl/fscm_ctrl.sv
`timescale 1ns/1ps
module fscm_ctrl
    import fscm_pkg::*;
(
    input  logic      int_clk,
    input  logic      rst,
    input  logic      ost_done,
    input  logic      fault,
    input  logic      fail_clr,
    output clk_mode_e mode,
    output logic      fail_flag
);
    always_ff @(posedge int_clk) begin
        if (rst) begin
            mode      <= MODE_BOOT;
            fail_flag <= 1'b0;
        end else begin
            unique case (mode)
                MODE_BOOT:    if (ost_done) mode <= MODE_PRIMARY;
                MODE_PRIMARY: if (fault)    mode <= MODE_SAFE;
                default:      mode <= MODE_SAFE;
            endcase
            if (mode == MODE_PRIMARY && fault) fail_flag <= 1'b1;
            else if (fail_clr)                 fail_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/fscm_top.sv
`timescale 1ns/1ps
module fscm_top
    import fscm_pkg::*;
#(
    parameter int SAMPLE_DIV  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic pri_clk,
    input  logic int_clk,
    input  logic rst,
    input  logic mon_en,
    input  logic ost_done,
    input  logic fail_clr,
    output logic sel_primary,
    output logic pri_active,
    output logic fail_flag
);
    clk_mode_e mode;
    mon_evt_t  evt;
    logic      tick;
    logic      arm;

    assign arm = drives_primary(mode) && mon_en;

    fscm_sample_div #(.DIV(SAMPLE_DIV)) u_div (
        .int_clk (int_clk),
        .rst     (rst),
        .tick    (tick)
    );

    fscm_edge_mon #(.SYNC(SYNC_STAGES)) u_mon (
        .int_clk (int_clk),
        .pri_clk (pri_clk),
        .rst     (rst),
        .arm     (arm),
        .tick    (tick),
        .evt     (evt)
    );

    fscm_ctrl u_ctrl (
        .int_clk   (int_clk),
        .rst       (rst),
        .ost_done  (ost_done),
        .fault     (evt.miss && mon_en),
        .fail_clr  (fail_clr),
        .mode      (mode),
        .fail_flag (fail_flag)
    );

    assign sel_primary = drives_primary(mode);
    assign pri_active  = (mode == MODE_PRIMARY) && !rst ? 1'b1 : 1'b0;
endmodule

// File: rtl/fscm_top_chk.sv
`timescale 1ns/1ps
module fscm_top_chk (
    input logic int_clk,
    input logic rst,
    input logic mon_en,
    input logic ost_done,
    input logic fail_clr,
    input logic sel_primary,
    input logic pri_active,
    input logic fail_flag
);
    p_status_match_r6: assert property (@(posedge int_clk) disable iff (rst)
        pri_active == sel_primary);

    p_enter_primary_r2: assert property (@(posedge int_clk) disable iff (rst)
        $rose(sel_primary) |-> $past(ost_done));

    p_flag_from_primary_r3: assert property (@(posedge int_clk) disable iff (rst)
        $rose(fail_flag) |-> $past(sel_primary));

    p_switch_with_flag_r5: assert property (@(posedge int_clk) disable iff (rst)
        $rose(fail_flag) |-> !sel_primary);

    p_drop_means_fail_r5: assert property (@(posedge int_clk) disable iff (rst)
        $fell(sel_primary) |-> fail_flag);

    p_flag_sticky_r7: assert property (@(posedge int_clk) disable iff (rst)
        (fail_flag && !fail_clr) |=> fail_flag);

    p_no_return_r7: assert property (@(posedge int_clk) disable iff (rst)
        (!sel_primary && fail_flag) |=> !sel_primary);

    p_gated_by_enable_r8: assert property (@(posedge int_clk) disable iff (rst)
        $rose(fail_flag) |-> $past(mon_en));
endmodule

bind fscm_top fscm_top_chk u_chk (
    .int_clk     (int_clk),
    .rst         (rst),
    .mon_en      (mon_en),
    .ost_done    (ost_done),
    .fail_clr    (fail_clr),
    .sel_primary (sel_primary),
    .pri_active  (pri_active),
    .fail_flag   (fail_flag)
);

// File: tb/fscm_top_tb.sv
`timescale 1ns/1ps
module fscm_top_tb;
    localparam int DIV = 16;

    logic pri_clk = 1'b0;
    logic int_clk = 1'b0;
    logic rst, mon_en, ost_done, fail_clr;
    logic sel_primary, pri_active, fail_flag;

    bit  pri_run = 1'b1;
    real pri_half = 3.5;
    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    fscm_top #(.SAMPLE_DIV(DIV)) u_dut (
        .pri_clk     (pri_clk),
        .int_clk     (int_clk),
        .rst         (rst),
        .mon_en      (mon_en),
        .ost_done    (ost_done),
        .fail_clr    (fail_clr),
        .sel_primary (sel_primary),
        .pri_active  (pri_active),
        .fail_flag   (fail_flag)
    );

    always #5 int_clk = ~int_clk;

    always begin
        if (pri_run) begin
            #(pri_half);
            if (pri_run) pri_clk = ~pri_clk;
        end else begin
            #1;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge int_clk);
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        real halves [6] = '{1.5, 2.5, 3.5, 5.0, 6.5, 8.5};
        int  lat;
        rst = 1'b1; mon_en = 1'b1; ost_done = 1'b0; fail_clr = 1'b0;
        cyc(6);
        check("R1", "sel in reset", int'(sel_primary), 0);
        check("R1", "status in reset", int'(pri_active), 0);
        check("R1", "flag in reset", int'(fail_flag), 0);
        rst = 1'b0;

        // R2: held on internal clock while start-up timer runs
        cyc(10 * DIV);
        check("R2", "sel while waiting", int'(sel_primary), 0);
        check("R2", "flag while waiting", int'(fail_flag), 0);

        // R3: primary never starting is not a fault during start-up
        pri_run = 1'b0;
        cyc(5 * DIV);
        check("R3", "flag with dead primary in start-up", int'(fail_flag), 0);
        check("R3", "sel with dead primary in start-up", int'(sel_primary), 0);

        pri_run = 1'b1;
        cyc(4);
        ost_done = 1'b1;
        cyc(1);
        check("R2", "sel one edge after ost_done", int'(sel_primary), 1);
        check("R6", "status on primary", int'(pri_active), 1);

        // R4: sweep of primary frequencies, none may be flagged
        foreach (halves[k]) begin
            pri_half = halves[k];
            cyc(20 * DIV);
            check("R4", $sformatf("flag at half %0.1f", halves[k]), int'(fail_flag), 0);
            check("R4", $sformatf("sel at half %0.1f", halves[k]), int'(sel_primary), 1);
        end

        // R8: detection disabled
        mon_en = 1'b0;
        pri_run = 1'b0;
        cyc(6 * DIV);
        check("R8", "flag with detection off", int'(fail_flag), 0);
        check("R8", "sel with detection off", int'(sel_primary), 1);
        pri_run = 1'b1;
        cyc(4 * DIV);
        mon_en = 1'b1;
        cyc(6 * DIV);
        check("R8", "flag after re-enable", int'(fail_flag), 0);

        // R5: stop the primary clock and measure detection latency
        pri_run = 1'b0;
        lat = -1;
        for (int i = 1; i <= 4 * DIV; i++) begin
            cyc(1);
            if (fail_flag) begin
                lat = i;
                break;
            end
        end
        check("R5", "flag raised", int'(fail_flag), 1);
        check("R5", "latency within bound", int'(lat > 0 && lat <= 2 * DIV + 8), 1);
        check("R5", "sel switched with flag", int'(sel_primary), 0);
        check("R6", "status on internal", int'(pri_active), 0);

        // R7: sticky flag, clear, no return to primary
        pri_run = 1'b1;
        cyc(3 * DIV);
        check("R7", "flag sticky after restart", int'(fail_flag), 1);
        check("R7", "sel stays internal after restart", int'(sel_primary), 0);
        fail_clr = 1'b1;
        cyc(1);
        fail_clr = 1'b0;
        check("R7", "flag cleared", int'(fail_flag), 0);
        cyc(5 * DIV);
        check("R7", "sel internal after clear", int'(sel_primary), 0);
        check("R7", "flag stays clear", int'(fail_flag), 0);

        // R9: reset after failure
        rst = 1'b1;
        cyc(3);
        check("R9", "sel in reset", int'(sel_primary), 0);
        check("R9", "flag in reset", int'(fail_flag), 0);
        rst = 1'b0;
        cyc(1);
        check("R9", "back on primary", int'(sel_primary), 1);

        // R10: primary period longer than a sample period
        pri_half = 100.0;
        lat = -1;
        for (int i = 1; i <= 8 * DIV; i++) begin
            cyc(1);
            if (fail_flag) begin
                lat = i;
                break;
            end
        end
        check("R10", "slow primary flagged", int'(fail_flag), 1);
        check("R10", "slow primary deselected", int'(sel_primary), 0);

        done = 1'b1;
        finish_run();
    end
endmodule